// File: doc/BRIEF.md
# Serial Transmitter with Automatic Clear-to-Send Gating

This block serializes bytes taken from a show-ahead transmit FIFO onto an asynchronous serial line using a fixed frame of one start bit, eight data bits and one stop bit. A baud tick at sixteen times the bit rate paces every bit. The FIFO presents its head byte and an empty flag. The block pulses a read strobe for one cycle at the moment it accepts that byte for transmission.

When automatic flow control is enabled, the active-low clear-to-send input decides whether a new character may begin. The input is first passed through a two-flop synchronizer. A character that has already started always finishes. The decision for the character that follows is made from a sample taken halfway through the stop bit of the current character. If the line was inactive at that sample, the next byte waits until clear-to-send becomes active again.

When automatic flow control is disabled, the transmitter ignores clear-to-send and drains the FIFO. Every clear-to-send transition then sets a sticky interrupt request, which the host clears with an acknowledge.

Top module: `uart_cts_tx`

## Requirements
- R1: A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit, each lasting sixteen baud ticks. The line is high whenever no frame is in progress.
- R2: `fifoRd` is a single-cycle pulse, asserted only while idle with the FIFO not empty. It captures `fifoData` in that cycle, and the start bit appears on `txOut` in the following cycle.
- R3: With `autoCtsEn` high, a frame leaves idle only when the synchronized clear-to-send is active (low), or when the stop-bit sample of the frame that just ended found it active.
- R4: With `autoCtsEn` high, clear-to-send is sampled on the eighth baud tick of the stop bit. If it is inactive (high) there, the current frame still completes and the next FIFO byte is held.
- R5: With `autoCtsEn` high, if clear-to-send goes inactive only after that eighth tick, the next byte still starts in the first idle cycle after the stop bit.
- R6: A held byte starts once `ctsN` returns low and has passed the two-flop synchronizer.
- R7: With `autoCtsEn` low, bytes are sent back to back regardless of `ctsN`.
- R8: With `autoCtsEn` low, each synchronized edge of `ctsN` sets `ctsIrq`, which stays set until `intAck` clears it. A set in the same cycle as an acknowledge wins.
- R9: With `autoCtsEn` high, `ctsN` edges never set `ctsIrq`.
- R10: After reset `txOut` is high, `fifoRd` is low and `ctsIrq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoData | input | 8 | Head byte of the transmit FIFO (show-ahead) |
| fifoEmpty | input | 1 | FIFO holds no byte |
| baudTick | input | 1 | Single-cycle pulse at sixteen times the bit rate |
| ctsN | input | 1 | Clear-to-send, active low, asynchronous |
| autoCtsEn | input | 1 | Enables automatic clear-to-send gating |
| intAck | input | 1 | Clears the clear-to-send change interrupt |
| txOut | output | 1 | Serial output line |
| fifoRd | output | 1 | One-cycle FIFO pop strobe |
| ctsIrq | output | 1 | Sticky clear-to-send change interrupt |

## Verification
The embedded properties check the following on every cycle:
- the read strobe is a single-cycle pulse;
- a load is always followed by a low start bit;
- the line is high while idle;
- an acknowledge clears the interrupt when no edge coincides with it;
- the interrupt never rises while gating is enabled.

The position of the stop-bit sample relative to clear-to-send changes can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. These scenarios cover deassertion before and after the midpoint, resumption after a hold, and draining with gating off.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } txState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadFrame;   // capture FIFO byte into the frame register
    logic shiftFrame;  // advance to the next bit
  } dpStrobe_t;

endpackage

// File: rtl/uart_cts_dp.sv
module uart_cts_dp
  import uart_cts_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [DATA_BITS-1:0] fifoData,
  output logic                 txOut
);

  localparam int FRAME_W = DATA_BITS + 2;

  logic [FRAME_W-1:0] frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
    end else if (strobe.loadFrame) begin
      frameReg <= {1'b1, fifoData, 1'b0};
    end else if (strobe.shiftFrame) begin
      frameReg <= {1'b1, frameReg[FRAME_W-1:1]};
    end
  end

  assign txOut = frameReg[0];

  // R1: a load always puts the start bit on the line next cycle
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFrame |=> !txOut);

endmodule

// File: rtl/uart_cts_ctrl.sv
module uart_cts_ctrl
  import uart_cts_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fifoEmpty,
  input  logic      baudTick,
  input  logic      ctsN,
  input  logic      autoCtsEn,
  input  logic      intAck,
  output logic      fifoRd,
  output logic      ctsIrq,
  output logic      busy,
  output dpStrobe_t strobe
);

  localparam int TW = $clog2(OVERSAMPLE);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(OVERSAMPLE - 1);
  localparam logic [TW-1:0] MID_TICK  = TW'(OVERSAMPLE / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);

  txState_e            state;
  logic [TW-1:0]       tickCnt;
  logic [BW-1:0]       bitCnt;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                ctsSync;
  logic                ctsEdge;
  logic                ctsActive;
  logic                mayStart;
  logic                bitEnd;
  logic                startOk;

  // Clear-to-send synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], ctsN};
    end
  end

  assign ctsSync   = syncChain[SYNC_STAGES-1];
  assign ctsEdge   = syncChain[SYNC_STAGES-1] ^ syncChain[SYNC_STAGES-2];
  assign ctsActive = !ctsSync;

  assign bitEnd  = baudTick && (tickCnt == LAST_TICK);
  assign startOk = !autoCtsEn || ctsActive || mayStart;
  assign fifoRd  = (state == TX_IDLE) && !fifoEmpty && startOk;
  assign busy    = (state != TX_IDLE);

  assign strobe.loadFrame  = fifoRd;
  assign strobe.shiftFrame = bitEnd && (state != TX_IDLE);

  // Frame sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= TX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      if (state != TX_IDLE && baudTick) begin
        tickCnt <= tickCnt + 1'b1;
      end
      unique case (state)
        TX_IDLE: begin
          if (fifoRd) begin
            state   <= TX_START;
            tickCnt <= '0;
            bitCnt  <= '0;
          end
        end
        TX_START: begin
          if (bitEnd) begin
            state <= TX_DATA;
          end
        end
        TX_DATA: begin
          if (bitEnd) begin
            if (bitCnt == LAST_BIT) begin
              state  <= TX_STOP;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        TX_STOP: begin
          if (bitEnd) begin
            state <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // Stop-bit midpoint sample: valid for the first idle cycle only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mayStart <= 1'b0;
    end else if (state == TX_IDLE) begin
      mayStart <= 1'b0;
    end else if (state == TX_STOP && baudTick && tickCnt == MID_TICK) begin
      mayStart <= ctsActive;
    end
  end

  // Sticky change interrupt, only without automatic gating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsIrq <= 1'b0;
    end else if (!autoCtsEn && ctsEdge) begin
      ctsIrq <= 1'b1;
    end else if (intAck) begin
      ctsIrq <= 1'b0;
    end
  end

  // R2: read strobe never lasts more than one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> !fifoRd);

  // R8: acknowledge clears the request when no edge coincides
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !(ctsEdge && !autoCtsEn)) |=> !ctsIrq);

  // R9: gating enabled keeps a clear request clear
  a_r9_no_irq_auto: assert property (@(posedge clk) disable iff (!rstN)
    (autoCtsEn && !ctsIrq) |=> !ctsIrq);

endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_cts_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_BITS-1:0] fifoData,
  input  logic                 fifoEmpty,
  input  logic                 baudTick,
  input  logic                 ctsN,
  input  logic                 autoCtsEn,
  input  logic                 intAck,
  output logic                 txOut,
  output logic                 fifoRd,
  output logic                 ctsIrq
);

  dpStrobe_t strobe;
  logic      busy;

  uart_cts_ctrl #(
    .DATA_BITS  (DATA_BITS),
    .OVERSAMPLE (OVERSAMPLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .fifoEmpty(fifoEmpty),
    .baudTick (baudTick),
    .ctsN     (ctsN),
    .autoCtsEn(autoCtsEn),
    .intAck   (intAck),
    .fifoRd   (fifoRd),
    .ctsIrq   (ctsIrq),
    .busy     (busy),
    .strobe   (strobe)
  );

  uart_cts_dp #(
    .DATA_BITS(DATA_BITS)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .fifoData(fifoData),
    .txOut   (txOut)
  );

  // R1: line rests high between frames
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

endmodule

// File: tb/uart_cts_tx_tb_top.sv
module uart_cts_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] fifoData = 8'h00;
  logic       fifoEmpty = 1'b1;
  logic       baudTick = 1'b0;
  logic       ctsN = 1'b0;
  logic       autoCtsEn = 1'b1;
  logic       intAck = 1'b0;
  logic       txOut;
  logic       fifoRd;
  logic       ctsIrq;

  always #4 clk = ~clk;  // 125 MHz

  uart_cts_tx dut_i (
    .clk(clk), .rstN(rstN), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .baudTick(baudTick), .ctsN(ctsN), .autoCtsEn(autoCtsEn), .intAck(intAck),
    .txOut(txOut), .fifoRd(fifoRd), .ctsIrq(ctsIrq)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rdSeen = 0;
  bit done = 0;

  // Behavioural reference model
  logic [7:0] q[$];
  int   mState = 0;   // 0 idle, 1 start, 2 data, 3 stop
  int   mTick = 0;
  int   mBit = 0;
  logic [7:0] mByte = 8'h00;
  bit   mS1 = 1, mS2 = 1, mMay = 0, mIrq = 0;

  function automatic bit expRd();
    return (mState == 0) && (q.size() > 0) && (!autoCtsEn || !mS2 || mMay);
  endfunction

  function automatic bit expTx();
    case (mState)
      1: return 1'b0;
      2: return mByte[mBit];
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (fifoRd) rdSeen++;
    if (!rstN) begin
      mState = 0; mTick = 0; mBit = 0; mS1 = 1; mS2 = 1; mMay = 0; mIrq = 0;
    end else begin
      automatic bit rd  = expRd();
      automatic bit edg = mS1 ^ mS2;
      automatic bit act = !mS2;
      automatic int st  = mState;
      if (!autoCtsEn && edg) mIrq = 1;
      else if (intAck) mIrq = 0;
      if (st == 0) mMay = 0;
      if (st == 3 && baudTick && mTick == 7) mMay = act;
      if (st == 0) begin
        if (rd) begin
          mByte = q.pop_front();
          mState = 1; mTick = 0; mBit = 0;
        end
      end else if (baudTick) begin
        if (mTick == 15) begin
          mTick = 0;
          if (st == 1) mState = 2;
          else if (st == 2) begin
            if (mBit == 7) begin mState = 3; mBit = 0; end
            else mBit++;
          end else mState = 0;
        end else mTick++;
      end
      mS2 = mS1;
      mS1 = ctsN;
    end
  end

  // Refresh FIFO view and baud tick, then compare every cycle
  always @(negedge clk) begin
    #1;
    fifoEmpty = (q.size() == 0);
    fifoData  = (q.size() > 0) ? q[0] : 8'h00;
    baudTick  = (cyc % 2 == 0);
    #1;
    if (rstN && !done) begin
      check(txOut === expTx(), "R1 txOut", txOut, expTx());
      check(fifoRd === expRd(), "R2 fifoRd", fifoRd, expRd());
      check(ctsIrq === mIrq, "R8 ctsIrq", ctsIrq, mIrq);
    end
  end

  task automatic waitStop(input int tick);
    while (!(mState == 3 && mTick == tick)) @(negedge clk);
  endtask

  task automatic waitIdleEmpty();
    while (!(mState == 0 && q.size() == 0)) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    finishRun();
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(txOut === 1'b1, "R10 txOut in reset", txOut, 1);
    check(fifoRd === 1'b0, "R10 fifoRd in reset", fifoRd, 0);
    check(ctsIrq === 1'b0, "R10 ctsIrq in reset", ctsIrq, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R3: basic frames with CTS active
    q.push_back(8'hA5); q.push_back(8'h3C); q.push_back(8'hFF); q.push_back(8'h00);
    waitIdleEmpty();
    repeat (2) @(negedge clk);
    check(rdSeen == 4, "R3 bytes sent with CTS active", rdSeen, 4);

    // R4: CTS inactive before the stop midpoint holds the next byte
    q.push_back(8'h81); q.push_back(8'h7E);
    waitStop(2);
    ctsN = 1'b1;
    r0 = rdSeen;
    repeat (300) @(negedge clk);
    check(rdSeen == r0, "R4 next byte held", rdSeen, r0);
    check(q.size() == 1, "R4 byte kept in FIFO", q.size(), 1);
    check(txOut === 1'b1, "R4 line idle while held", txOut, 1);

    // R6: resume after CTS returns low
    ctsN = 1'b0;
    repeat (5) @(negedge clk);
    check(rdSeen == r0 + 1, "R6 resumed after CTS low", rdSeen, r0 + 1);

    // R5: CTS inactive after the midpoint still lets next byte go
    q.push_back(8'h5A);
    waitStop(12);
    ctsN = 1'b1;
    r0 = rdSeen;
    while (mState != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(rdSeen == r0 + 1, "R5 byte after late deassert", rdSeen, r0 + 1);
    waitIdleEmpty();
    repeat (4) @(negedge clk);
    check(ctsIrq === 1'b0, "R9 no irq with gating on", ctsIrq, 0);

    // R7: gating off drains FIFO with CTS inactive
    autoCtsEn = 1'b0;
    r0 = rdSeen;
    q.push_back(8'hC3); q.push_back(8'h96);
    waitIdleEmpty();
    repeat (2) @(negedge clk);
    check(rdSeen == r0 + 2, "R7 drained regardless of CTS", rdSeen, r0 + 2);

    // R8: edge sets sticky irq, ack clears it
    ctsN = 1'b0;
    repeat (6) @(negedge clk);
    check(ctsIrq === 1'b1, "R8 irq set by edge", ctsIrq, 1);
    repeat (20) @(negedge clk);
    check(ctsIrq === 1'b1, "R8 irq sticky", ctsIrq, 1);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
    @(negedge clk);
    check(ctsIrq === 1'b0, "R8 irq cleared by ack", ctsIrq, 0);

    // R9: edges with gating on do not raise irq
    autoCtsEn = 1'b1;
    ctsN = 1'b1;
    repeat (6) @(negedge clk);
    ctsN = 1'b0;
    repeat (6) @(negedge clk);
    check(ctsIrq === 1'b0, "R9 edges ignored for irq", ctsIrq, 0);

    // R2: empty FIFO never read
    r0 = rdSeen;
    repeat (50) @(negedge clk);
    check(rdSeen == r0, "R2 no read when empty", rdSeen, r0);

    finishRun();
  end

endmodule